// File: doc/BRIEF.md
# Character Output Device Controller

This block is the output side of a character terminal attached to a 12-bit accumulator processor. It has no memory of its own. When the processor executes an I/O transfer instruction, the decoded instruction bits, the accumulator and the next program counter arrive with a one-cycle strobe. The block reacts only when the device-select field of the instruction bits holds its own device code. The low three instruction bits then pick one of five operations on a 12-bit control register. Three of those operations write the register, one tests it, and one loads a character.

The control register holds an 8-bit character in bits [7:0], a pending bit at bit 8, a ready flag at bit 9 and a companion status bit at bit 10. A pending character goes to a serial transmitter as a byte with a one-cycle valid pulse. When the transmitter acknowledges it, the pending bit clears and the ready flag sets. The test operation turns the ready flag into a skip by returning the next program counter with its low 12 bits incremented. Function codes that the device does not implement raise an error pulse.

Top module: `char_out_ctl`

## Requirements
- R1: A strobe whose instruction bits [8:3] differ from octal 04 changes no register and raises neither `skip` nor `bad_op`.
- R2: Function 0 sets the control register to 0x600, which sets bits 9 and 10 and clears every other bit.
- R3: Function 1 asserts `skip` for one cycle when bit 9 of the control register is set, and leaves the register unchanged.
- R4: Function 2 clears the whole control register to zero.
- R5: Function 4 keeps bits [11:9], sets bit 8, and loads bits [7:0] with accumulator bits [7:0] XOR 0x80.
- R6: Function 6 keeps bit 11, clears bits 10 and 9, sets bit 8, and loads bits [7:0] with accumulator bits [7:0] XOR 0x80.
- R7: After any legal device strobe, `pc_out` equals `next_pc`. When the strobe skips, bits [11:0] are incremented modulo 4096 and bits [14:12] are kept.
- R8: Function codes 3, 5 and 7 pulse `bad_op` for one cycle and change neither the control register nor `pc_out`.
- R9: When bit 8 sets, `tx_valid` pulses for exactly one cycle, with `tx_data` equal to the stored character. Each load gives one pulse.
- R10: A `tx_ack` that arrives after the pulse, while bit 8 is set, clears bit 8 and sets bit 9. An ack with nothing in flight, or one that coincides with a register-writing strobe, is ignored.
- R11: A synchronous active-high `rst` clears the register, `skip`, `bad_op`, `tx_valid`, `tx_data` and `pc_out`.
- R12: Every register change and every output caused by a strobe appears on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_strobe | input | 1 | Instruction strobe, one cycle per I/O instruction |
| iot_bits | input | 9 | Instruction bits: [8:3] device select, [2:0] function |
| acc | input | 12 | Accumulator value |
| next_pc | input | 15 | Next program counter, with the field in bits [14:12] |
| tx_ack | input | 1 | Transmitter has taken the character |
| skip | output | 1 | Skip request, one cycle |
| pc_out | output | 15 | Next program counter after any skip |
| tx_data | output | 8 | Character toward the transmitter |
| tx_valid | output | 1 | One-cycle character valid pulse |
| ctl_state | output | 12 | Control register contents |
| bad_op | output | 1 | Unimplemented function code on this device, one cycle |

## Verification
The vector table steps through every function code in turn, starting from different register contents. This shows whether each of the two load operations uses the correct clearing mask: with bit 9 set, function 4 keeps it and function 6 drops it. Skip vectors use program counters whose low 12 bits are all ones, both with a nonzero field and with a zero field, so that wrap and field preservation are both observed. The inverted character bit is checked with a character that has bit 7 set and with one that has it clear. Foreign device codes and the three unimplemented function codes are given after a load, so any stray write would show. Directed tests then count the valid pulses for one load, and send acks at three moments: in flight, with nothing pending, and together with a load.

// File: rtl/char_out_pkg.sv
package char_out_pkg;

  localparam int unsigned FN_W = 3;

  localparam logic [FN_W-1:0] FN_ARM   = 3'd0;
  localparam logic [FN_W-1:0] FN_TEST  = 3'd1;
  localparam logic [FN_W-1:0] FN_CLEAR = 3'd2;
  localparam logic [FN_W-1:0] FN_LOAD  = 3'd4;
  localparam logic [FN_W-1:0] FN_SEND  = 3'd6;

  typedef struct packed {
    logic sel;
    logic arm;
    logic test;
    logic clr;
    logic load;
    logic send;
    logic bad;
  } op_t;

  function automatic logic op_writes(op_t op);
    return op.arm | op.clr | op.load | op.send;
  endfunction

endpackage

// File: rtl/char_out_decode.sv
module char_out_decode
  import char_out_pkg::*;
#(
  parameter int unsigned DEV_W    = 6,
  parameter logic [DEV_W-1:0] DEV_CODE = 6'o04,
  localparam int unsigned BITS_W  = DEV_W + FN_W
) (
  input  logic              strobe,
  input  logic [BITS_W-1:0] bits,
  output op_t               op
);

  logic          hit;
  logic [FN_W-1:0] fn;

  assign hit = strobe && (bits[BITS_W-1:FN_W] == DEV_CODE);
  assign fn  = bits[FN_W-1:0];

  always_comb begin
    op     = '0;
    op.sel = hit;
    if (hit) begin
      unique case (fn)
        FN_ARM:   op.arm  = 1'b1;
        FN_TEST:  op.test = 1'b1;
        FN_CLEAR: op.clr  = 1'b1;
        FN_LOAD:  op.load = 1'b1;
        FN_SEND:  op.send = 1'b1;
        default:  op.bad  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/char_out_ctlreg.sv
module char_out_ctlreg
  import char_out_pkg::*;
#(
  parameter int unsigned CTL_W  = 12,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned ACC_W  = 12,
  localparam int unsigned PEND_B = CHAR_W,
  localparam int unsigned FLAG_B = CHAR_W + 1,
  localparam int unsigned AUX_B  = CHAR_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  op_t              op,
  input  logic [ACC_W-1:0] acc,
  input  logic             tx_ack,
  output logic [CTL_W-1:0] ctl,
  output logic             fire
);

  localparam logic [CTL_W-1:0] ARM_VAL   = (CTL_W'(1) << FLAG_B) | (CTL_W'(1) << AUX_B);
  localparam logic [CTL_W-1:0] LOAD_KEEP = ~((CTL_W'(1) << FLAG_B) - CTL_W'(1));
  localparam logic [CTL_W-1:0] SEND_KEEP = ~((CTL_W'(1) << (AUX_B + 1)) - CTL_W'(1));
  localparam logic [CHAR_W-1:0] TOP_FLIP = CHAR_W'(1) << (CHAR_W - 1);

  logic              issued;
  logic [CHAR_W-1:0] ch;
  logic [CTL_W-1:0]  loaded;
  logic              writes;

  assign ch     = acc[CHAR_W-1:0] ^ TOP_FLIP;
  assign loaded = (CTL_W'(1) << PEND_B) | CTL_W'(ch);
  assign writes = op_writes(op);
  assign fire   = ctl[PEND_B] && !issued && !writes;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      issued <= 1'b0;
    end else if (writes) begin
      issued <= 1'b0;
      if (op.arm)       ctl <= ARM_VAL;
      else if (op.clr)  ctl <= '0;
      else if (op.load) ctl <= (ctl & LOAD_KEEP) | loaded;
      else              ctl <= (ctl & SEND_KEEP) | loaded;
    end else begin
      if (fire) issued <= 1'b1;
      if (tx_ack && ctl[PEND_B] && issued) begin
        ctl[PEND_B] <= 1'b0;
        ctl[FLAG_B] <= 1'b1;
        issued      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/char_out_txport.sv
module char_out_txport #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CHAR_W-1:0] ch,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= fire;
      if (fire) tx_data <= ch;
    end
  end

endmodule

// File: rtl/char_out_pcstep.sv
module char_out_pcstep
  import char_out_pkg::*;
#(
  parameter int unsigned PC_W   = 15,
  parameter int unsigned WORD_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  op_t             op,
  input  logic            flag,
  input  logic [PC_W-1:0] next_pc,
  output logic            skip,
  output logic            bad_op,
  output logic [PC_W-1:0] pc_out
);

  logic [PC_W-1:0]   stepped;
  logic [WORD_W-1:0] low_inc;
  logic              take;

  assign low_inc = next_pc[WORD_W-1:0] + WORD_W'(1);
  assign take    = op.test && flag;

  generate
    if (PC_W > WORD_W) begin : g_field
      assign stepped = {next_pc[PC_W-1:WORD_W], low_inc};
    end else begin : g_flat
      assign stepped = low_inc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      skip   <= 1'b0;
      bad_op <= 1'b0;
      pc_out <= '0;
    end else begin
      skip   <= 1'b0;
      bad_op <= op.bad;
      if (op.sel && !op.bad) begin
        skip   <= take;
        pc_out <= take ? stepped : next_pc;
      end
    end
  end

endmodule

// File: rtl/char_out_ctl.sv
module char_out_ctl
  import char_out_pkg::*;
#(
  parameter int unsigned DEV_W    = 6,
  parameter logic [DEV_W-1:0] DEV_CODE = 6'o04,
  parameter int unsigned CTL_W    = 12,
  parameter int unsigned CHAR_W   = 8,
  parameter int unsigned ACC_W    = 12,
  parameter int unsigned PC_W     = 15,
  localparam int unsigned BITS_W  = DEV_W + FN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iot_strobe,
  input  logic [BITS_W-1:0] iot_bits,
  input  logic [ACC_W-1:0]  acc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic              tx_ack,
  output logic              skip,
  output logic [PC_W-1:0]   pc_out,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  output logic [CTL_W-1:0]  ctl_state,
  output logic              bad_op
);

  op_t  op;
  logic fire;

  char_out_decode #(.DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_dec (
    .strobe (iot_strobe),
    .bits   (iot_bits),
    .op     (op)
  );

  char_out_ctlreg #(.CTL_W(CTL_W), .CHAR_W(CHAR_W), .ACC_W(ACC_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .acc    (acc),
    .tx_ack (tx_ack),
    .ctl    (ctl_state),
    .fire   (fire)
  );

  char_out_txport #(.CHAR_W(CHAR_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .ch       (ctl_state[CHAR_W-1:0]),
    .tx_data  (tx_data),
    .tx_valid (tx_valid)
  );

  char_out_pcstep #(.PC_W(PC_W), .WORD_W(ACC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .flag    (ctl_state[CHAR_W+1]),
    .next_pc (next_pc),
    .skip    (skip),
    .bad_op  (bad_op),
    .pc_out  (pc_out)
  );

endmodule

// File: rtl/char_out_ctl_chk.sv
module char_out_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        iot_strobe,
  input logic [8:0]  iot_bits,
  input logic [11:0] acc,
  input logic [14:0] next_pc,
  input logic        tx_ack,
  input logic        skip,
  input logic [14:0] pc_out,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic [11:0] ctl_state,
  input logic        bad_op
);

  logic mine;
  assign mine = iot_strobe && (iot_bits[8:3] == 6'o04);

  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd0 |=> ctl_state == 12'h600);

  assert_test_R3: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd1 && !tx_ack |=> skip == $past(ctl_state[9]) && $stable(ctl_state));

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd2 |=> ctl_state == 12'h000);

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd4 |=> ctl_state[8]
      && ctl_state[7:0] == ($past(acc[7:0]) ^ 8'h80)
      && ctl_state[11:9] == $past(ctl_state[11:9]));

  assert_send_R6: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd6 |=> ctl_state[8] && ctl_state[10:9] == 2'b00
      && ctl_state[11] == $past(ctl_state[11]));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    mine && iot_bits[2:0] == 3'd1 && ctl_state[9] |=>
      pc_out == {$past(next_pc[14:12]), $past(next_pc[11:0]) + 12'd1});

  assert_bad_R8: assert property (@(posedge clk) disable iff (rst)
    mine && (iot_bits[2:0] == 3'd3 || iot_bits[2:0] == 3'd5 || iot_bits[2:0] == 3'd7)
      |=> bad_op && $stable(ctl_state) && $stable(pc_out));

  assert_foreign_R1: assert property (@(posedge clk) disable iff (rst)
    iot_strobe && !mine && !tx_ack |=> $stable(ctl_state) && !skip && !bad_op);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> ctl_state == 12'h000 && !tx_valid && !skip && !bad_op);

endmodule

bind char_out_ctl char_out_ctl_chk u_chk (.*);

// File: tb/test_char_out_ctl.sv
`timescale 1ns/1ps
module test_char_out_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iot_strobe = 1'b0;
  logic [8:0]  iot_bits = '0;
  logic [11:0] acc = '0;
  logic [14:0] next_pc = '0;
  logic        tx_ack = 1'b0;
  logic        skip;
  logic [14:0] pc_out;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic [11:0] ctl_state;
  logic        bad_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  char_out_ctl i_char_out_ctl (.*);

  typedef struct packed {
    logic [8:0]  bits;
    logic [11:0] a;
    logic [14:0] pc;
    logic [11:0] ectl;
    logic        eskip;
    logic [14:0] epc;
    logic        eerr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{9'o041, 12'h000, 15'o12345, 12'h000, 1'b0, 15'o12345, 1'b0},
    '{9'o040, 12'h000, 15'o00100, 12'h600, 1'b0, 15'o00100, 1'b0},
    '{9'o041, 12'h000, 15'o17777, 12'h600, 1'b1, 15'o10000, 1'b0},
    '{9'o044, 12'h041, 15'o00200, 12'h7C1, 1'b0, 15'o00200, 1'b0},
    '{9'o046, 12'hFFF, 15'o00300, 12'h17F, 1'b0, 15'o00300, 1'b0},
    '{9'o041, 12'h000, 15'o70007, 12'h17F, 1'b0, 15'o70007, 1'b0},
    '{9'o045, 12'h123, 15'o11111, 12'h17F, 1'b0, 15'o70007, 1'b1},
    '{9'o043, 12'h456, 15'o22222, 12'h17F, 1'b0, 15'o70007, 1'b1},
    '{9'o047, 12'h789, 15'o33333, 12'h17F, 1'b0, 15'o70007, 1'b1},
    '{9'o050, 12'h055, 15'o44444, 12'h17F, 1'b0, 15'o70007, 1'b0},
    '{9'o000, 12'h0AA, 15'o55555, 12'h17F, 1'b0, 15'o70007, 1'b0},
    '{9'o042, 12'h000, 15'o00400, 12'h000, 1'b0, 15'o00400, 1'b0},
    '{9'o044, 12'h0A5, 15'o00500, 12'h125, 1'b0, 15'o00500, 1'b0},
    '{9'o040, 12'h000, 15'o00600, 12'h600, 1'b0, 15'o00600, 1'b0},
    '{9'o044, 12'h080, 15'o00700, 12'h700, 1'b0, 15'o00700, 1'b0},
    '{9'o041, 12'h000, 15'o07777, 12'h700, 1'b1, 15'o00000, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [8:0] b);
    if (b[8:3] != 6'o04) return "R1";
    case (b[2:0])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R5";
      3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  // one strobe cycle; outputs are sampled at the negedge after the capturing edge (R12)
  task automatic strobe(input logic [8:0] b, input logic [11:0] a, input logic [14:0] pc, input logic ack);
    @(negedge clk);
    iot_bits = b; acc = a; next_pc = pc; iot_strobe = 1'b1; tx_ack = ack;
    @(negedge clk);
    iot_strobe = 1'b0; tx_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pulses;
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11", "ctl after reset", 32'(ctl_state), 32'h000);
    chk("R11", "tx_valid after reset", 32'(tx_valid), 32'h0);
    chk("R11", "pc_out after reset", 32'(pc_out), 32'h0);

    for (int i = 0; i < NV; i++) begin
      strobe(TBL[i].bits, TBL[i].a, TBL[i].pc, 1'b0);
      chk(req_of(TBL[i].bits), $sformatf("ctl vec %0d", i), 32'(ctl_state), 32'(TBL[i].ectl));
      chk("R7", $sformatf("skip vec %0d", i), 32'(skip), 32'(TBL[i].eskip));
      chk("R7", $sformatf("pc_out vec %0d", i), 32'(pc_out), 32'(TBL[i].epc));
      chk("R8", $sformatf("bad_op vec %0d", i), 32'(bad_op), 32'(TBL[i].eerr));
    end

    // R9 one pulse per load with the stored character
    strobe(9'o042, 12'h000, 15'o0, 1'b0);
    strobe(9'o044, 12'h033, 15'o0, 1'b0);
    chk("R5", "load 0x33", 32'(ctl_state), 32'h1B3);
    chk("R12", "no pulse at strobe edge", 32'(tx_valid), 32'h0);
    pulses = 0; seen = '0;
    for (int k = 0; k < 6; k++) begin
      if (tx_valid) begin pulses++; seen = tx_data; end
      @(negedge clk);
    end
    chk("R9", "pulse count", 32'(pulses), 32'd1);
    chk("R9", "tx_data", 32'(seen), 32'hB3);

    // R10 ack in flight
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    chk("R10", "ack completes", 32'(ctl_state), 32'h2B3);
    strobe(9'o041, 12'h000, 15'o01234, 1'b0);
    chk("R3", "skip after ack", 32'(skip), 32'h1);
    chk("R7", "pc after ack skip", 32'(pc_out), 32'(15'o01235));

    // R10 ack with nothing pending ignored
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    chk("R10", "idle ack ignored", 32'(ctl_state), 32'h2B3);

    // R10 ack together with a load ignored
    strobe(9'o044, 12'h011, 15'o0, 1'b1);
    chk("R10", "ack with load", 32'(ctl_state), 32'h391);

    // R11 reset mid-operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "ctl after mid reset", 32'(ctl_state), 32'h000);
    chk("R11", "pc_out after mid reset", 32'(pc_out), 32'h0);
    chk("R11", "tx_valid after mid reset", 32'(tx_valid), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule